// File: doc/BRIEF.md
# Subcache Probe Predictor

This block decides which subcache of a partitioned cache is probed first for each incoming request, and steers the probing that follows when that guess is wrong. An eight-entry, fully associative identifier buffer remembers which subcache held each recently used page tag. The lookup finishes in the same cycle as the request. When the buffer has no matching entry, a single register holding the most recently used subcache supplies the guess instead.

A probe that misses starts a walk. The walk tries the other subcaches one per cycle, in rising ID order, wrapping from the highest ID to zero. It stops at the first hit. When every subcache has been tried without a hit, the block reports a full miss and names the subcache that the fetched block should fill. Spatial data always fills the spatial subcache and temporal data always fills the temporal subcache. Bypass data fills whichever of the two has recorded fewer misses. The subcache arrays answer the probes through a hit input, and the memory fetch happens outside this block.

Top module: `sc_predictor`

## Requirements
- R1: When a request is accepted and its tag matches a valid buffer entry, `pred_valid_o` is 1 in that same cycle, and the first probe goes to the subcache stored in that entry.
- R2: When the tag matches no buffer entry, `pred_valid_o` is 0 and the first probe goes to the most recently used subcache. This is the subcache named by the last completed result, and it is 0 after reset.
- R3: After a probe misses, the next probe follows in the next cycle and goes to the following ID, where ID NUM_SC-1 is followed by 0. The walk ends after NUM_SC probes, so no subcache is probed twice for one request.
- R4: When a probe hits, `res_valid_o` is 1 in the next cycle, with `res_hit_o`=1, `res_id_o` set to the subcache that hit, and `res_probes_o` set to the number of probes used.
- R5: When all NUM_SC probes miss, `res_valid_o` is 1 in the cycle after the last probe, with `res_hit_o`=0, `res_probes_o`=NUM_SC, and `res_id_o` set to the fill subcache.
- R6: The `req_cls_i` encoding is 0 for spatial, 1 for temporal, and 2 or 3 for bypass. On a full miss, spatial data fills subcache SP_ID (0) and temporal data fills subcache TP_ID (1). Bypass data fills TP_ID only when the miss count of TP_ID is strictly lower than that of SP_ID; otherwise it fills SP_ID.
- R7: Each subcache has a miss counter. The counter increases by one on every full miss that fills that subcache, and it holds at 2^CNT_W-1 (15 by default).
- R8: Every completed result writes the request's tag into the buffer, paired with the result subcache. A stale entry is corrected in place, and a missing tag replaces the least recently used of the eight entries. A later request with the same tag is then predicted to go to that subcache.
- R9: `req_ready_o` is 0 while a walk is in progress, and no request is accepted during that time.
- R10: After reset, `req_ready_o` is 1, `res_valid_o` is 0, and `probe_valid_o` is 0 while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, so a request is accepted this cycle |
| req_tag_i | input | TAG_W | Page tag of the request |
| req_cls_i | input | 2 | Data class: 0 spatial, 1 temporal, 2 or 3 bypass |
| pred_valid_o | output | 1 | The buffer matched the accepted request |
| probe_valid_o | output | 1 | A subcache is probed this cycle |
| probe_id_o | output | ID_W | Subcache being probed |
| probe_hit_i | input | 1 | The probed subcache holds the data (same cycle) |
| res_valid_o | output | 1 | Result strobe |
| res_hit_o | output | 1 | 1 for a hit, 0 for a full miss |
| res_id_o | output | ID_W | Subcache that hit, or the fill subcache |
| res_probes_o | output | PR_W | Number of probes used |

## Verification
The assertions rely on `probe_hit_i` being a same-cycle answer that is meaningful only while `probe_valid_o` is high. They also rely on the data for one request staying in the same subcache until that request's result appears. The bench answers probes from a single "holder" value that it fixes before it presents each request. It changes which subcache holds a tag only while the block is idle. It fills the model's holder only after the full-miss result has been seen, so the stimulus never violates these assumptions.

// File: rtl/sc_pred_pkg.sv
package sc_pred_pkg;
  typedef enum logic [1:0] {
    CLS_SPATIAL  = 2'd0,
    CLS_TEMPORAL = 2'd1,
    CLS_BYPASS   = 2'd2
  } sc_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/sc_id_buf.sv
module sc_id_buf #(
  parameter int TAG_W = 20,
  parameter int ID_W  = 2,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [ID_W-1:0]  lk_id_o,
  input  logic             upd_en_i,
  input  logic             upd_old_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [ID_W-1:0]  upd_id_i
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [IDX_W-1:0] age_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IDX_W-1:0] vict_idx, tgt_idx;

  always_comb begin
    lk_hit_o = 1'b0;
    lk_idx_o = '0;
    lk_id_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && tag_q[i] == lk_tag_i) begin
        lk_hit_o = 1'b1;
        lk_idx_o = IDX_W'(i);
        lk_id_o  = id_q[i];
      end
    end
  end

  // ages form a permutation; the oldest entry is the victim
  always_comb begin
    vict_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_q[i] == IDX_W'(DEPTH - 1)) vict_idx = IDX_W'(i);
    end
  end

  assign tgt_idx = upd_old_i ? upd_idx_i : vict_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
        id_q[g]  <= '0;
        vld_q[g] <= 1'b0;
        age_q[g] <= IDX_W'(DEPTH - 1 - g);
      end else if (upd_en_i) begin
        if (tgt_idx == IDX_W'(g)) begin
          tag_q[g] <= upd_tag_i;
          id_q[g]  <= upd_id_i;
          vld_q[g] <= 1'b1;
          age_q[g] <= '0;
        end else if (age_q[g] < age_q[tgt_idx]) begin
          age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_place.sv
module sc_place
  import sc_pred_pkg::*;
#(
  parameter int NUM_SC = 4,
  parameter int CNT_W  = 4,
  parameter int SP_ID  = 0,
  parameter int TP_ID  = 1,
  localparam int ID_W  = (NUM_SC > 1) ? $clog2(NUM_SC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      cls_i,
  output logic [ID_W-1:0] tgt_o,
  input  logic            miss_en_i,
  input  logic [ID_W-1:0] miss_id_i
);
  logic [CNT_W-1:0] cnt_q [NUM_SC];

  for (genvar g = 0; g < NUM_SC; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (miss_en_i && miss_id_i == ID_W'(g) && cnt_q[g] != {CNT_W{1'b1}}) begin
        cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    case (sc_cls_e'(cls_i))
      CLS_SPATIAL:  tgt_o = ID_W'(SP_ID);
      CLS_TEMPORAL: tgt_o = ID_W'(TP_ID);
      default:      tgt_o = (cnt_q[TP_ID] < cnt_q[SP_ID]) ? ID_W'(TP_ID) : ID_W'(SP_ID);
    endcase
  end
endmodule

// File: rtl/sc_predictor.sv
module sc_predictor
  import sc_pred_pkg::*;
#(
  parameter int NUM_SC    = 4,
  parameter int TAG_W     = 20,
  parameter int BUF_DEPTH = 8,
  parameter int CNT_W     = 4,
  parameter int SP_ID     = 0,
  parameter int TP_ID     = 1,
  localparam int ID_W     = (NUM_SC > 1) ? $clog2(NUM_SC) : 1,
  localparam int PR_W     = $clog2(NUM_SC + 1),
  localparam int IDX_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [1:0]       req_cls_i,
  output logic             pred_valid_o,
  output logic             probe_valid_o,
  output logic [ID_W-1:0]  probe_id_o,
  input  logic             probe_hit_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [ID_W-1:0]  res_id_o,
  output logic [PR_W-1:0]  res_probes_o
);
  walk_st_e         st_q;
  logic [TAG_W-1:0] tag_q;
  logic [1:0]       cls_q;
  logic [ID_W-1:0]  cur_q, mru_q;
  logic [PR_W-1:0]  done_q;
  logic             lkh_q;
  logic [IDX_W-1:0] lki_q;

  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [ID_W-1:0]  lk_id, place_id, fin_id, next_id;
  logic             accept, walking, fin_hit, fin_miss, fin;
  logic [PR_W-1:0]  cnt_now;
  logic [TAG_W-1:0] cur_tag;
  logic [1:0]       cur_cls;
  logic             cur_lkh;
  logic [IDX_W-1:0] cur_lki;

  logic             res_valid_q, res_hit_q;
  logic [ID_W-1:0]  res_id_q;
  logic [PR_W-1:0]  res_probes_q;

  assign walking       = (st_q == ST_WALK);
  assign req_ready_o   = !walking;
  assign accept        = req_valid_i && !walking;
  assign pred_valid_o  = accept && lk_hit;
  assign probe_valid_o = accept || walking;
  assign probe_id_o    = walking ? cur_q : (lk_hit ? lk_id : mru_q);
  assign next_id       = (probe_id_o == ID_W'(NUM_SC - 1)) ? '0 : probe_id_o + 1'b1;
  assign cnt_now       = walking ? done_q + 1'b1 : PR_W'(1);
  assign fin_hit       = probe_valid_o && probe_hit_i;
  assign fin_miss      = probe_valid_o && !probe_hit_i && (cnt_now == PR_W'(NUM_SC));
  assign fin           = fin_hit || fin_miss;

  assign cur_tag = walking ? tag_q : req_tag_i;
  assign cur_cls = walking ? cls_q : req_cls_i;
  assign cur_lkh = walking ? lkh_q : lk_hit;
  assign cur_lki = walking ? lki_q : lk_idx;
  assign fin_id  = fin_hit ? probe_id_o : place_id;

  sc_id_buf #(
    .TAG_W (TAG_W),
    .ID_W  (ID_W),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_tag_i  (req_tag_i),
    .lk_hit_o  (lk_hit),
    .lk_idx_o  (lk_idx),
    .lk_id_o   (lk_id),
    .upd_en_i  (fin),
    .upd_old_i (cur_lkh),
    .upd_idx_i (cur_lki),
    .upd_tag_i (cur_tag),
    .upd_id_i  (fin_id)
  );

  sc_place #(
    .NUM_SC (NUM_SC),
    .CNT_W  (CNT_W),
    .SP_ID  (SP_ID),
    .TP_ID  (TP_ID)
  ) u_place (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cls_i     (cur_cls),
    .tgt_o     (place_id),
    .miss_en_i (fin_miss),
    .miss_id_i (place_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tag_q  <= '0;
      cls_q  <= '0;
      lkh_q  <= 1'b0;
      lki_q  <= '0;
      cur_q  <= '0;
      done_q <= '0;
    end else begin
      st_q <= (probe_valid_o && !fin) ? ST_WALK : ST_IDLE;
      if (accept) begin
        tag_q <= req_tag_i;
        cls_q <= req_cls_i;
        lkh_q <= lk_hit;
        lki_q <= lk_idx;
      end
      if (probe_valid_o && !fin) begin
        cur_q  <= next_id;
        done_q <= cnt_now;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q  <= 1'b0;
      res_hit_q    <= 1'b0;
      res_id_q     <= '0;
      res_probes_q <= '0;
      mru_q        <= '0;
    end else begin
      res_valid_q <= fin;
      if (fin) begin
        res_hit_q    <= fin_hit;
        res_id_q     <= fin_id;
        res_probes_q <= cnt_now;
        mru_q        <= fin_id;
      end
    end
  end

  assign res_valid_o  = res_valid_q;
  assign res_hit_o    = res_hit_q;
  assign res_id_o     = res_id_q;
  assign res_probes_o = res_probes_q;
endmodule

// File: rtl/sc_predictor_chk.sv
module sc_predictor_chk #(
  parameter int NUM_SC = 4,
  parameter int ID_W   = 2,
  parameter int PR_W   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            probe_valid_o,
  input logic [ID_W-1:0] probe_id_o,
  input logic            probe_hit_i,
  input logic            res_valid_o,
  input logic            res_hit_o,
  input logic [ID_W-1:0] res_id_o,
  input logic [PR_W-1:0] res_probes_o
);
  function automatic logic [ID_W-1:0] step_id(logic [ID_W-1:0] x);
    return (x == ID_W'(NUM_SC - 1)) ? '0 : x + 1'b1;
  endfunction

  AST_ACCEPT_PROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> probe_valid_o); // R1

  AST_WALK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_o && !probe_hit_i) |=>
      ((res_valid_o && !res_hit_o) ||
       (probe_valid_o && probe_id_o == step_id($past(probe_id_o))))); // R3

  AST_HIT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_o && probe_hit_i) |=>
      (res_valid_o && res_hit_o && res_id_o == $past(probe_id_o))); // R4

  AST_MISS_ALL_TRIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_probes_o == PR_W'(NUM_SC))); // R5

  AST_FILL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_id_o <= ID_W'(NUM_SC - 1))); // R6

  AST_BUSY_PROBING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> probe_valid_o); // R9
endmodule

bind sc_predictor sc_predictor_chk #(
  .NUM_SC (NUM_SC),
  .ID_W   (ID_W),
  .PR_W   (PR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .probe_valid_o (probe_valid_o),
  .probe_id_o    (probe_id_o),
  .probe_hit_i   (probe_hit_i),
  .res_valid_o   (res_valid_o),
  .res_hit_o     (res_hit_o),
  .res_id_o      (res_id_o),
  .res_probes_o  (res_probes_o)
);

// File: tb/sc_predictor_bench.sv
module sc_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSC   = 4;
  localparam int TAGW  = 20;
  localparam int DEPTH = 8;
  localparam int SATV  = 15;
  localparam int IDW   = 2;
  localparam int PRW   = 3;

  typedef struct {
    bit    hit;
    int    id;
    int    probes;
    string rq;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [TAGW-1:0] req_tag = '0;
  logic [1:0]      req_cls = '0;
  logic            pred_valid, probe_valid, probe_hit;
  logic [IDW-1:0]  probe_id;
  logic            res_valid, res_hit;
  logic [IDW-1:0]  res_id;
  logic [PRW-1:0]  res_probes;

  int n_chk = 0;
  int n_bad = 0;
  int hold_id = -1;
  int mru = 0;
  int cnt [NSC];
  int ltag[$];
  int lid[$];
  int owner[int];
  exp_t expq[$];
  int next_tag = 16'h100;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign probe_hit = probe_valid && (hold_id >= 0) && (int'(probe_id) == hold_id);

  sc_predictor u_sc_predictor (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .req_tag_i     (req_tag),
    .req_cls_i     (req_cls),
    .pred_valid_o  (pred_valid),
    .probe_valid_o (probe_valid),
    .probe_id_o    (probe_id),
    .probe_hit_i   (probe_hit),
    .res_valid_o   (res_valid),
    .res_hit_o     (res_hit),
    .res_id_o      (res_id),
    .res_probes_o  (res_probes)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int find_tag(input int t);
    for (int i = 0; i < ltag.size(); i++) if (ltag[i] == t) return i;
    return -1;
  endfunction

  function automatic int fill_of(input int cls);
    if (cls == 0) return 0;
    if (cls == 1) return 1;
    return (cnt[1] < cnt[0]) ? 1 : 0;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(res_hit == e.hit, {e.rq, " hit flag"}, int'(res_hit), int'(e.hit));
        chk(int'(res_id) == e.id, {e.rq, " result id"}, int'(res_id), e.id);
        chk(int'(res_probes) == e.probes, {e.rq, " probe count"}, int'(res_probes), e.probes);
      end
    end
  end

  task automatic run_req(input int tag, input int cls, input string rq);
    int   idx, first, h, k;
    exp_t e;
    while (!req_ready) @(negedge clk);
    idx   = find_tag(tag);
    first = (idx >= 0) ? lid[idx] : mru;
    h     = owner.exists(tag) ? owner[tag] : -1;
    e.rq  = rq;
    if (h < 0) begin
      e.hit = 1'b0; e.id = fill_of(cls); e.probes = NSC;
    end else begin
      e.hit = 1'b1; e.id = h; e.probes = 1 + ((h - first + NSC) % NSC);
    end
    expq.push_back(e);
    hold_id   = h;
    req_tag   = TAGW'(tag);
    req_cls   = 2'(cls);
    req_valid = 1'b1;
    #1;
    chk(pred_valid == (idx >= 0), (idx >= 0) ? "R1 prediction flag" : "R2 no-prediction flag",
        int'(pred_valid), int'(idx >= 0));
    chk(probe_valid && int'(probe_id) == first, (idx >= 0) ? "R1 first probe" : "R2 default probe",
        int'(probe_id), first);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!res_valid) begin
      chk(probe_valid && int'(probe_id) == (first + k) % NSC, "R3 reprobe order",
          int'(probe_id), (first + k) % NSC);
      chk(!req_ready, "R9 busy while walking", int'(req_ready), 0);
      k++;
      @(negedge clk);
    end
    if (idx >= 0) begin
      ltag.delete(idx);
      lid.delete(idx);
    end
    ltag.push_front(tag);
    lid.push_front(e.id);
    if (ltag.size() > DEPTH) begin
      void'(ltag.pop_back());
      void'(lid.pop_back());
    end
    mru = e.id;
    if (!e.hit) begin
      owner[tag] = e.id;
      if (cnt[e.id] < SATV) cnt[e.id]++;
    end
  endtask

  function automatic int new_tag();
    next_tag++;
    return next_tag;
  endfunction

  initial begin
    int ta, tb, tc, td, te;
    for (int i = 0; i < NSC; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R10 no result after reset", int'(res_valid), 0);
    chk(probe_valid == 1'b0, "R10 no probe while idle", int'(probe_valid), 0);

    ta = new_tag();
    run_req(ta, 0, "R5 spatial full miss");
    run_req(ta, 0, "R1 predicted hit");
    tb = new_tag();
    run_req(tb, 1, "R6 temporal fill");
    tc = new_tag(); owner[tc] = 3;
    run_req(tc, 0, "R3 walk to subcache 3");
    td = new_tag(); owner[td] = 0;
    run_req(td, 1, "R3 wraparound walk");
    owner[ta] = 2;
    run_req(ta, 0, "R8 stale entry walk");
    run_req(ta, 0, "R8 corrected prediction");
    te = new_tag();
    run_req(te, 2, "R6 bypass tie");
    run_req(new_tag(), 3, "R6 bypass lower count");
    for (int i = 0; i < DEPTH + 1; i++) run_req(new_tag(), 0, "R8 fill buffer");
    run_req(ta, 0, "R8 evicted entry");
    run_req(tc, 1, "R2 unpredicted hit");
    for (int i = 0; i < 10; i++) run_req(new_tag(), 0, "R7 spatial misses");
    for (int i = 0; i < 17; i++) run_req(new_tag(), 1, "R7 temporal misses");
    run_req(new_tag(), 2, "R7 saturated bypass");
    run_req(new_tag(), 2, "R7 saturated bypass again");
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 all results seen", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule